// File: doc/BRIEF.md
# Converter Sample Gain and Offset Trim

This block corrects each raw converter sample for gain and offset error with a fixed-point affine map: the calibrated code is a gain coefficient times the raw sample plus an offset coefficient. Raw 12-bit samples arrive in a signed 16-bit word, qualified by a valid strobe. The gain coefficient is a signed 16-bit value with 15 fraction bits. The offset coefficient is a signed 16-bit value with 10 fraction bits. Software loads both coefficients into two write-only holding registers through a strobe-and-data pair each.

The datapath has three registered stages. The first forms the full-width signed product. The second shifts the product right by the difference in fraction bits so that its binary point matches the offset's, then adds the offset. The third drops the remaining fraction bits and clamps the integer result to the unsigned code range. A flag marks every sample whose result was forced onto a rail. The offset that travels with a sample is captured together with it in the first stage. A sample therefore always sees one consistent pair of coefficients, even when a write lands while earlier samples are still in flight.

Top module: `adc_trim_core`

## Requirements
- R1: `out_valid` is asserted exactly three clock cycles after the edge that captured `in_valid` high, and is low in every other cycle.
- R2: The product of gain and sample is kept at the full 32-bit signed width (15 fraction bits), with no truncation. Gain −32768 times sample −32768 therefore gives +2^30, which saturates to 4095.
- R3: The product is aligned by an arithmetic right shift of 5 bits, which rounds toward minus infinity. With gain 1, offset 5120 and sample −1, the output is 4.
- R4: The unclamped code is floor((floor(gain·sample / 32) + offset) / 1024). With gain 32422 and offset −23303, sample 437 gives 409 and sample 3749 gives 3686.
- R5: An unclamped code below 0 is output as 0 with `out_sat` high.
- R6: An unclamped code above 4095 is output as 4095 with `out_sat` high. An in-range code is output unchanged with `out_sat` low.
- R7: A coefficient write takes effect at the clock edge that captures it. A sample captured at that same edge still uses the previous coefficient. A sample captured at any later edge uses the new one.
- R8: While `out_valid` is low, `out_code` and `out_sat` keep the values of the last valid result.
- R9: After reset, `out_valid`, `out_code` and `out_sat` are 0. The gain coefficient is 0x7FFF and the offset is 0, so sample 1000 with no prior write gives 999.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| gain_wr_en | input | 1 | Load strobe for the gain coefficient |
| gain_wr_data | input | 16 | Gain coefficient, signed, 15 fraction bits |
| offs_wr_en | input | 1 | Load strobe for the offset coefficient |
| offs_wr_data | input | 16 | Offset coefficient, signed, 10 fraction bits |
| in_valid | input | 1 | Raw sample qualifier |
| in_sample | input | 16 | Raw sample, signed integer |
| out_valid | output | 1 | Calibrated code qualifier |
| out_code | output | 12 | Calibrated, clamped code |
| out_sat | output | 1 | High when the code was clamped to a rail |

## Verification
A sample and any coefficient write presented before a given edge produce their result on the outputs after the third edge. The bench drives inputs on falling edges and keeps a three-entry queue of expected results. At each falling edge it compares the outputs with the entry that has aged three cycles. Every expected value is taken from the coefficients the bench's model held when the sample entered the pipeline. The model then applies that step's writes, so a write in the same cycle as a sample affects only later samples. In cycles with nothing due, the bench checks that the outputs repeat the last valid result.

// File: rtl/adc_trim_pkg.sv
package adc_trim_pkg;

   typedef enum logic [1:0] {
      CLAMP_NONE = 2'd0,
      CLAMP_LOW  = 2'd1,
      CLAMP_HIGH = 2'd2
   } trim_clamp_e;

endpackage

// File: rtl/trim_mul_stage.sv
module trim_mul_stage #(
   parameter int SAMPLE_W = 16,
   parameter int COEF_W   = 16,
   localparam int PROD_W  = SAMPLE_W + COEF_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [SAMPLE_W-1:0] in_sample,
   input  logic signed [COEF_W-1:0]   gain,
   input  logic signed [COEF_W-1:0]   offs,
   output logic                     s1_valid,
   output logic signed [PROD_W-1:0]   s1_prod,
   output logic signed [COEF_W-1:0]   s1_offs
);

   // Offset is captured beside the product so the pair stays consistent.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_prod  <= '0;
         s1_offs  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_prod <= in_sample * gain;
            s1_offs <= offs;
         end
      end
   end

endmodule

// File: rtl/trim_align_stage.sv
module trim_align_stage #(
   parameter int PROD_W   = 32,
   parameter int COEF_W   = 16,
   parameter int ALIGN_SH = 5,
   localparam int SUM_W   = PROD_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s1_valid,
   input  logic signed [PROD_W-1:0]  s1_prod,
   input  logic signed [COEF_W-1:0]  s1_offs,
   output logic                    s2_valid,
   output logic signed [SUM_W-1:0]   s2_sum
);

   logic signed [PROD_W-1:0] aligned;
   logic signed [SUM_W-1:0]  sum_next;

   generate
      if (ALIGN_SH > 0) begin : g_shift
         assign aligned = s1_prod >>> ALIGN_SH;
      end else begin : g_pass
         assign aligned = s1_prod;
      end
   endgenerate

   assign sum_next = SUM_W'(aligned) + SUM_W'(s1_offs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_sum   <= '0;
      end else begin
         s2_valid <= s1_valid;
         if (s1_valid) s2_sum <= sum_next;
      end
   end

endmodule

// File: rtl/trim_clamp_stage.sv
module trim_clamp_stage
   import adc_trim_pkg::*;
#(
   parameter int SUM_W     = 33,
   parameter int OFFS_FRAC = 10,
   parameter int CODE_W    = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   s2_valid,
   input  logic signed [SUM_W-1:0]  s2_sum,
   output logic                   out_valid,
   output logic [CODE_W-1:0]      out_code,
   output logic                   out_sat
);

   localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((64'd1 << CODE_W) - 64'd1);

   logic signed [SUM_W-1:0] code_full;
   trim_clamp_e             clamp_kind;
   logic [CODE_W-1:0]       code_next;

   assign code_full = s2_sum >>> OFFS_FRAC;

   always_comb begin
      if (code_full < 0)             clamp_kind = CLAMP_LOW;
      else if (code_full > CODE_MAX) clamp_kind = CLAMP_HIGH;
      else                           clamp_kind = CLAMP_NONE;
      case (clamp_kind)
         CLAMP_LOW:  code_next = '0;
         CLAMP_HIGH: code_next = '1;
         default:    code_next = code_full[CODE_W-1:0];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
         out_sat   <= 1'b0;
      end else begin
         out_valid <= s2_valid;
         if (s2_valid) begin
            out_code <= code_next;
            out_sat  <= (clamp_kind != CLAMP_NONE);
         end
      end
   end

   // R5 and R6: a flagged result sits on one of the two rails
   assert_sat_on_rail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_sat |-> (out_code == '0 || out_code == '1));

   // R8: outputs are held while no result is delivered
   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !s2_valid |=> ($stable(out_code) && $stable(out_sat)));

endmodule

// File: rtl/adc_trim_core.sv
module adc_trim_core #(
   parameter int SAMPLE_W  = 16,
   parameter int COEF_W    = 16,
   parameter int GAIN_FRAC = 15,
   parameter int OFFS_FRAC = 10,
   parameter int CODE_W    = 12,
   parameter logic [COEF_W-1:0] GAIN_INIT = 16'h7FFF,
   parameter logic [COEF_W-1:0] OFFS_INIT = 16'h0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gain_wr_en,
   input  logic [COEF_W-1:0]   gain_wr_data,
   input  logic                offs_wr_en,
   input  logic [COEF_W-1:0]   offs_wr_data,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   output logic                out_valid,
   output logic [CODE_W-1:0]   out_code,
   output logic                out_sat
);

   localparam int PROD_W   = SAMPLE_W + COEF_W;
   localparam int ALIGN_SH = GAIN_FRAC - OFFS_FRAC;
   localparam int SUM_W    = PROD_W + 1;

   generate
      if (GAIN_FRAC < OFFS_FRAC) begin : g_bad_frac
         $error("gain fraction bits must not be fewer than offset fraction bits");
      end
      if (GAIN_FRAC >= COEF_W) begin : g_bad_gain
         $error("gain fraction bits must leave a sign bit");
      end
      if (CODE_W >= SAMPLE_W) begin : g_bad_code
         $error("code width must be narrower than the sample word");
      end
   endgenerate

   logic signed [COEF_W-1:0] gain_q;
   logic signed [COEF_W-1:0] offs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q <= GAIN_INIT;
         offs_q <= OFFS_INIT;
      end else begin
         if (gain_wr_en) gain_q <= gain_wr_data;
         if (offs_wr_en) offs_q <= offs_wr_data;
      end
   end

   logic                     s1_valid;
   logic signed [PROD_W-1:0] s1_prod;
   logic signed [COEF_W-1:0] s1_offs;
   logic                     s2_valid;
   logic signed [SUM_W-1:0]  s2_sum;

   trim_mul_stage #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) i_mul (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .gain(gain_q), .offs(offs_q),
      .s1_valid(s1_valid), .s1_prod(s1_prod), .s1_offs(s1_offs));

   trim_align_stage #(.PROD_W(PROD_W), .COEF_W(COEF_W), .ALIGN_SH(ALIGN_SH)) i_align (
      .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_prod(s1_prod),
      .s1_offs(s1_offs), .s2_valid(s2_valid), .s2_sum(s2_sum));

   trim_clamp_stage #(.SUM_W(SUM_W), .OFFS_FRAC(OFFS_FRAC), .CODE_W(CODE_W)) i_clamp (
      .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_sum(s2_sum),
      .out_valid(out_valid), .out_code(out_code), .out_sat(out_sat));

   // Edges seen since reset, saturating, so the latency check never looks before reset.
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R1: fixed three-cycle latency on the qualifier
   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   // R7: coefficients change only on a write strobe
   assert_gain_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !gain_wr_en |=> $stable(gain_q));
   assert_offs_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !offs_wr_en |=> $stable(offs_q));

endmodule

// File: tb/test_adc_trim_core.sv
module test_adc_trim_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gain_wr_en = 1'b0;
   logic [15:0] gain_wr_data = '0;
   logic        offs_wr_en = 1'b0;
   logic [15:0] offs_wr_data = '0;
   logic        in_valid = 1'b0;
   logic [15:0] in_sample = '0;
   logic        out_valid;
   logic [11:0] out_code;
   logic        out_sat;

   always #2.5 clk = ~clk;

   adc_trim_core i_adc_trim_core (
      .clk(clk), .rst_n(rst_n),
      .gain_wr_en(gain_wr_en), .gain_wr_data(gain_wr_data),
      .offs_wr_en(offs_wr_en), .offs_wr_data(offs_wr_data),
      .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(out_valid), .out_code(out_code), .out_sat(out_sat));

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Model state
   logic signed [15:0] m_gain = 16'sh7FFF;
   logic signed [15:0] m_offs = 16'sh0000;
   bit          q_v[3];
   logic [11:0] q_code[3];
   bit          q_sat[3];
   string       q_tag[3];
   logic [11:0] held_code = '0;
   bit          held_sat = 1'b0;

   function automatic logic [12:0] model(input logic signed [15:0] raw,
                                         input logic signed [15:0] g,
                                         input logic signed [15:0] o);
      longint p, a, s, c;
      p = longint'(g) * longint'(raw);
      a = p >>> 5;
      s = a + longint'(o);
      c = s >>> 10;
      if (c < 0)         return {1'b1, 12'd0};
      else if (c > 4095) return {1'b1, 12'd4095};
      else               return {1'b0, 12'(c)};
   endfunction

   task automatic check(input string tag, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input logic [15:0] raw,
                       input bit gw, input logic [15:0] gd,
                       input bit ow, input logic [15:0] od,
                       input string tag);
      logic [12:0] r;
      @(negedge clk);
      // compare the entry captured three edges ago
      check("R1", "out_valid", out_valid, q_v[2]);
      if (q_v[2]) begin
         check(q_tag[2], "out_code", out_code, q_code[2]);
         check(q_tag[2], "out_sat", out_sat, q_sat[2]);
         held_code = q_code[2];
         held_sat  = q_sat[2];
      end else begin
         check("R8", "held out_code", out_code, held_code);
         check("R8", "held out_sat", out_sat, held_sat);
      end
      for (int k = 2; k > 0; k--) begin
         q_v[k] = q_v[k-1]; q_code[k] = q_code[k-1];
         q_sat[k] = q_sat[k-1]; q_tag[k] = q_tag[k-1];
      end
      r = model(raw, m_gain, m_offs);
      q_v[0] = v; q_code[0] = r[11:0]; q_sat[0] = r[12];
      if (tag != "")    q_tag[0] = tag;
      else if (r[12])   q_tag[0] = (r[11:0] == 12'd0) ? "R5" : "R6";
      else              q_tag[0] = "R4";
      // writes become visible only to later samples
      if (gw) m_gain = gd;
      if (ow) m_offs = od;
      in_valid = v; in_sample = raw;
      gain_wr_en = gw; gain_wr_data = gd;
      offs_wr_en = ow; offs_wr_data = od;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, 16'd0, 1'b0, 16'd0, 1'b0, 16'd0, "");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 3; k++) begin
         q_v[k] = 1'b0; q_code[k] = '0; q_sat[k] = 1'b0; q_tag[k] = "R8";
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state at the outputs
      check("R9", "reset out_valid", out_valid, 0);
      check("R9", "reset out_code", out_code, 0);
      check("R9", "reset out_sat", out_sat, 0);
      rst_n = 1'b1;

      // R9: default coefficients
      step(1'b1, 16'd1000, 1'b0, 16'd0, 1'b0, 16'd0, "R9");
      idle(3);

      // R4: worked points; R7: writes in the cycle of a sample
      step(1'b0, 16'd0, 1'b1, 16'd32422, 1'b1, 16'hA4F9, "");
      step(1'b1, 16'd437, 1'b0, 16'd0, 1'b0, 16'd0, "R4");
      step(1'b1, 16'd3749, 1'b0, 16'd0, 1'b0, 16'd0, "R4");
      step(1'b1, 16'd2000, 1'b1, 16'd16384, 1'b1, 16'd0, "R7");
      step(1'b1, 16'd2000, 1'b0, 16'd0, 1'b0, 16'd0, "R7");
      idle(3);

      // R3: arithmetic alignment shift on a negative product
      step(1'b1, 16'd31, 1'b1, 16'd1, 1'b1, 16'd5120, "R3");
      step(1'b1, 16'hFFFF, 1'b0, 16'd0, 1'b0, 16'd0, "R3");
      step(1'b1, 16'hFFFF, 1'b0, 16'd0, 1'b0, 16'd0, "R3");
      // R2: full product width at the corner
      step(1'b1, 16'h8000, 1'b1, 16'h8000, 1'b1, 16'd0, "R2");
      step(1'b1, 16'h8000, 1'b0, 16'd0, 1'b0, 16'd0, "R2");
      // R5 / R6: rails and a just-in-range code
      step(1'b1, 16'd10, 1'b1, 16'd32422, 1'b1, 16'hA4F9, "R5");
      step(1'b1, 16'd10, 1'b0, 16'd0, 1'b0, 16'd0, "R5");
      step(1'b1, 16'd4200, 1'b0, 16'd0, 1'b0, 16'd0, "R6");
      step(1'b1, 16'd4160, 1'b1, 16'd32767, 1'b1, 16'd0, "R6");
      step(1'b1, 16'd4095, 1'b0, 16'd0, 1'b0, 16'd0, "R6");
      idle(4);

      // Constrained random traffic
      void'($urandom(32'd20221));
      for (int k = 0; k < 400; k++) begin
         bit v, gw, ow;
         logic [15:0] raw, gd, od;
         v   = ($urandom_range(3, 0) != 0);
         raw = 16'($urandom_range(4400, 0)) - 16'd150;
         gw  = ($urandom_range(15, 0) == 0);
         ow  = ($urandom_range(15, 0) == 0);
         gd  = 16'($urandom_range(32767, 29000));
         od  = 16'($urandom_range(60000, 0)) - 16'd30000;
         step(v, raw, gw, gd, ow, od, "");
      end
      idle(4);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule